// File: doc/BRIEF.md
# Queued Pulse Delay Line

This block replays every rising edge of its pulse input as a single-cycle pulse on its output, a programmable number of clock cycles later. Unlike a one-shot timer that is deaf while it counts, it keeps accepting new edges while earlier ones are still waiting. Each accepted edge is held until its own delay has run out.

A free-running tick counter of CNT_W bits serves as the clock of record. On an accepted rising edge, the block writes the counter value and the present delay setting into a fixed-depth first-in first-out store. Only the oldest entry is compared with the counter. Once the modulo-2^CNT_W difference between the counter and that entry's timestamp reaches the entry's own delay, the block pops the entry and raises the output for one cycle. Two status outputs report a full store and a sticky overflow. A pulse that arrives while the store is full is lost, and the overflow flag records the loss.

Top module: `pulse_delay_queue`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, pulse_out, fifo_full and overflow are 0. Reset discards every pending entry, so nothing queued before reset appears at the output afterwards.
- R2: If clock edge C samples pulse_in at 1 after a sample of 0, and the entry is accepted, pulse_out is 1 for exactly one cycle. That cycle directly follows clock edge C+D, where D is the delay_in value sampled at edge C and 1 <= D < 2^CNT_W.
- R3: A level held high over several edges creates only one entry. A further entry needs pulse_in to return to 0 for at least one sampled edge.
- R4: Up to DEPTH edges may be pending at once. Each one produces its own output pulse at its own due cycle, in arrival order.
- R5: delay_in is captured together with the timestamp. A change to delay_in after the capture edge does not move that entry's output.
- R6: The tick counter wraps modulo 2^CNT_W. An entry whose wait straddles the wrap still fires on the cycle R2 gives.
- R7: fifo_full is 1 exactly while DEPTH entries are pending.
- R8: When a new edge arrives on the same clock edge on which a full store pops its oldest entry, the new entry is accepted and is not counted as lost.
- R9: An edge that arrives while the store is full, with no pop on that clock edge, is dropped and never produces an output. overflow becomes 1 after that clock edge and stays 1 until reset.
- R10: A delay of 0 acts as a delay of 1. An entry whose elapsed time already exceeds its delay when it reaches the head fires in the cycle after it becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Pulse input; its rising edges are queued |
| delay_in | input | CNT_W | Delay in clock cycles, captured with each entry |
| pulse_out | output | 1 | Delayed single-cycle pulse |
| fifo_full | output | 1 | All DEPTH entries are in use |
| overflow | output | 1 | Sticky: an input edge was lost |

## Verification
Take the clock edge that first samples a new high level on pulse_in. The output pulse is due in the cycle after the D-th edge that follows it, so the bench records the due edge number in an expected-output map at the moment it drives the pulse. fifo_full and overflow change after the capture or pop edge itself. The bench therefore derives them each cycle from the set of entries still due, which is the same map. All outputs are compared at every falling edge against the map entry for the number of rising edges seen so far, so each result is checked in exactly the cycle it becomes visible and in no other.

// File: rtl/pulse_delay_queue.sv
module pulse_delay_queue #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] delay_in,
  output logic             pulse_out,
  output logic             fifo_full,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] now;
  logic             pulse_q;
  logic [CNT_W-1:0] ts_mem [DEPTH];
  logic [CNT_W-1:0] dl_mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [CNT_W-1:0] elapsed;
  logic             rise, fire, push;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rise      = pulse_in & ~pulse_q;
  assign elapsed   = now - ts_mem[rd_ptr];
  assign fire      = (count != '0) && (elapsed >= dl_mem[rd_ptr]);
  assign fifo_full = (count == CW'(DEPTH));
  assign push      = rise && (!fifo_full || fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now       <= '0;
      pulse_q   <= 1'b0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      pulse_out <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      now       <= now + 1'b1;
      pulse_q   <= pulse_in;
      pulse_out <= fire;
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (fire) rd_ptr <= ptr_inc(rd_ptr);
      if (push && !fire)      count <= count + 1'b1;
      else if (fire && !push) count <= count - 1'b1;
      if (rise && !push) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ts_mem[wr_ptr] <= now;
      dl_mem[wr_ptr] <= delay_in;
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  fire_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> $past(count != '0));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fifo_full && rise));

  // R3
  level_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pulse_in) && $past(pulse_q)) |-> count <= $past(count));
endmodule

// File: tb/pulse_delay_queue_tb.sv
module pulse_delay_queue_tb_top;
  localparam int CW   = 8;
  localparam int DP   = 4;
  localparam int MAPN = 4096;
  localparam int NV   = 10;
  localparam int V_GAP   [NV] = '{3, 2, 2, 2, 40, 1, 1, 30, 5, 3};
  localparam int V_WIDTH [NV] = '{1, 1, 2, 1, 1, 1, 3, 1, 1, 2};
  localparam int V_DELAY [NV] = '{12, 12, 12, 12, 5, 5, 5, 200, 200, 200};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pulse_in = 1'b0;
  logic [CW-1:0] delay_in = '0;
  logic          pulse_out, fifo_full, overflow;

  pulse_delay_queue #(.CNT_W(CW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .delay_in(delay_in),
    .pulse_out(pulse_out), .fifo_full(fifo_full), .overflow(overflow));

  always #4 clk = ~clk;

  int    ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  bit    exp_map [MAPN];
  int    ovf_edge = 1 << 30;
  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    prev_p = 1'b0;
  bit    done = 1'b0;

  function automatic int pend_after(input int m);
    int s = 0;
    for (int i = 1; i < 256; i++) s += int'(exp_map[(m + i) % MAPN]);
    return s;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic step(input bit p, input int d);
    int c, dd;
    bit ef, eo;
    @(negedge clk);
    chk(pulse_out === exp_map[ecnt % MAPN], "pulse_out", int'(pulse_out),
        int'(exp_map[ecnt % MAPN]));
    exp_map[ecnt % MAPN] = 1'b0;
    ef = (pend_after(ecnt) == DP);
    chk(fifo_full === ef, "R7 fifo_full", int'(fifo_full), int'(ef));
    eo = (ecnt >= ovf_edge);
    chk(overflow === eo, "R9 overflow", int'(overflow), int'(eo));
    if (p && !prev_p) begin
      c  = ecnt + 1;
      dd = (d == 0) ? 1 : d;
      if (pend_after(c) < DP) exp_map[(c + dd) % MAPN] = 1'b1;
      else if (ovf_edge > c) ovf_edge = c;
    end
    prev_p   = p;
    pulse_in = p;
    delay_in = CW'(d);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs are low during reset
    tag = "R1";
    chk(pulse_out === 1'b0 && fifo_full === 1'b0 && overflow === 1'b0,
        "R1 outputs in reset", int'({pulse_out, fifo_full, overflow}), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 10);

    // R2 R3 R4 R7: vector table, delays grouped so due times stay ordered
    for (int i = 0; i < NV; i++) begin
      tag = (V_WIDTH[i] > 1) ? "R3" : "R4";
      repeat (V_GAP[i]) step(0, V_DELAY[i]);
      repeat (V_WIDTH[i]) step(1, V_DELAY[i]);
    end
    tag = "R2";
    repeat (260) step(0, 200);

    // R5: delay change after capture has no effect on the entry
    tag = "R5";
    step(1, 20);
    step(0, 3);
    repeat (30) step(0, 3);

    // R10: a delay of 0 behaves as 1
    tag = "R10";
    step(1, 0);
    repeat (6) step(0, 0);

    // R8: push on the edge that pops a full store is kept
    tag = "R8";
    for (int k = 0; k < 5; k++) begin
      step(1, 8);
      step(0, 8);
    end
    repeat (20) step(0, 8);

    // R6: a long wait straddles the counter wrap
    tag = "R6";
    step(1, 250);
    repeat (260) step(0, 250);

    // R9: fifth and sixth edges find the store full and are lost
    tag = "R9";
    for (int k = 0; k < 6; k++) begin
      step(1, 30);
      step(0, 30);
    end
    repeat (40) step(0, 30);

    // R1: reset mid-run clears the sticky flag and pending entries
    tag = "R1";
    step(1, 100);
    step(0, 100);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < MAPN; i++) exp_map[i] = 1'b0;
    ovf_edge = 1 << 30;
    prev_p = 1'b0;
    pulse_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(overflow === 1'b0, "R1 overflow cleared", int'(overflow), 0);
    rst_n = 1'b1;
    repeat (150) step(0, 100);

    finish_run();
  end
endmodule